// File: doc/BRIEF.md
# Card Clock Divider with Update Handshake

This unit produces the clock sent to a memory card from the host's source clock. Software programs a divider, an enable and a source-select value into staging registers, then issues an update-only command. The staging values do nothing on their own. They are copied into the active set in one cycle when the command completes, and the command's start flag clears by itself at that point.

The update can be told to wait until any data transfer in progress has finished. Software then polls the start flag. If a second command is written while one is still pending, that write is discarded and a sticky lock-error flag is raised. In divided mode the card clock is a register toggled by a counter. A zero divider passes the source clock through, behind a gate that changes only while the source is low. Enable changes in either mode take effect only while the card clock is low.

Top module: `card_clk_ctrl`

## Requirements
- R1: After reset, `card_clk_o` is low, `clk_src_o` is 0, the pending flag (bit 31 of the command word, address 3) reads 0, and the raw status word (address 4) reads 0.
- R2: Writes to the divider (address 0, bits 7:0), enable (address 1, bit 0) and source (address 2, bits 1:0) registers change neither `card_clk_o` nor `clk_src_o` until an update completes. Reads of these addresses return the staged values.
- R3: A write to address 3 with bits 31 and 21 both set and bit 13 clear sets the pending flag, which reads back 1 in the following cycle. The staged values are applied on the next clock edge, and the pending flag then reads 0.
- R4: With an active divider D from 1 to 255 and the clock enabled, `card_clk_o` stays high for D source cycles and then low for D source cycles, giving the source frequency divided by 2·D.
- R5: With an active divider of 0 and the clock enabled, `card_clk_o` follows the source clock. With the clock disabled, it stays low.
- R6: If bit 13 of the update command is set, the update is held while `data_busy_i` is high, and it is applied on the first edge after `data_busy_i` falls. Without bit 13, a high `data_busy_i` does not delay the update. Bit 9 of the status word (address 5) reflects `data_busy_i`.
- R7: A write to address 3 while an update is pending sets bit 12 of the raw status word and leaves the pending update unchanged. Writing a 1 to bit 12 at address 4 clears the flag.
- R8: A write to address 3 that does not have both bit 31 and bit 21 set leaves the pending flag at 0 and the active settings unchanged.
- R9: A disable that is applied during a high phase does not shorten that phase. The clock finishes its full D cycles high and then stays low.
- R10: `clk_src_o` takes the staged source value exactly when an update is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| data_busy_i | input | 1 | A data transfer is in progress |
| card_clk_o | output | 1 | Gated, divided card clock |
| clk_src_o | output | 2 | Active clock-source select |

## Verification
If the pending flag gets stuck, the command word reads wrong the cycle after an update is issued, and the outputs never take the staged values. If the active set is loaded at the wrong time, `clk_src_o` or the clock period changes before the start flag drops, or one cycle late. A corrupted divider counter or gate shows within one card-clock period, as a phase length other than D or as a short high pulse when the clock is disabled. A lost lock flag shows on the next read of the raw status word after a command is written twice.

// File: rtl/cck_pkg.sv
package cck_pkg;
  localparam int unsigned CMD_START_BIT = 31;
  localparam int unsigned CMD_UPD_BIT   = 21;
  localparam int unsigned CMD_WAIT_BIT  = 13;
  localparam int unsigned RAW_LOCK_BIT  = 12;
  localparam int unsigned STAT_BUSY_BIT = 9;

  typedef enum logic [2:0] {
    A_DIV  = 3'd0,
    A_ENA  = 3'd1,
    A_SRC  = 3'd2,
    A_CMD  = 3'd3,
    A_RAW  = 3'd4,
    A_STAT = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/cck_upd.sv
module cck_upd
  import cck_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              busy_i,
  output logic              pend_o,
  output logic              wait_o,
  output logic              apply_o,
  output logic              err_set_o
);
  logic pend_q, wait_q, start_req;

  assign start_req = cmd_data_i[CMD_START_BIT] & cmd_data_i[CMD_UPD_BIT];
  assign apply_o   = pend_q & ~(wait_q & busy_i);
  assign err_set_o = cmd_wr_i & pend_q;
  assign pend_o    = pend_q;
  assign wait_o    = wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      wait_q <= 1'b0;
    end else if (apply_o) begin
      pend_q <= 1'b0;
    end else if (cmd_wr_i && !pend_q && start_req) begin
      pend_q <= 1'b1;
      wait_q <= cmd_data_i[CMD_WAIT_BIT];
    end
  end
endmodule

// File: rtl/cck_regs.sv
module cck_regs
  import cck_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned SRC_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              apply_i,
  input  logic              err_set_i,
  input  logic              pend_i,
  input  logic              busy_i,
  output logic [DIV_W-1:0]  act_div_o,
  output logic              act_en_o,
  output logic [SRC_W-1:0]  act_src_o,
  output logic              lock_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DIV_W-1:0] sh_div_q;
  logic             sh_en_q;
  logic [SRC_W-1:0] sh_src_q;
  logic             lock_q;
  logic             wr_div, wr_ena, wr_src, wr_raw;

  assign wr_div = wr_en_i && (wr_addr_i == ADDR_W'(A_DIV));
  assign wr_ena = wr_en_i && (wr_addr_i == ADDR_W'(A_ENA));
  assign wr_src = wr_en_i && (wr_addr_i == ADDR_W'(A_SRC));
  assign wr_raw = wr_en_i && (wr_addr_i == ADDR_W'(A_RAW));

  // staged copies, written directly by software
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_div_q <= '0;
      sh_en_q  <= 1'b0;
      sh_src_q <= '0;
    end else begin
      if (wr_div) sh_div_q <= wr_data_i[DIV_W-1:0];
      if (wr_ena) sh_en_q  <= wr_data_i[0];
      if (wr_src) sh_src_q <= wr_data_i[SRC_W-1:0];
    end
  end

  // active set, loaded as a whole only on apply
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_div_o <= '0;
      act_en_o  <= 1'b0;
      act_src_o <= '0;
    end else if (apply_i) begin
      act_div_o <= sh_div_q;
      act_en_o  <= sh_en_q;
      act_src_o <= sh_src_q;
    end
  end

  // sticky lock error, set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              lock_q <= 1'b0;
    else if (err_set_i)                       lock_q <= 1'b1;
    else if (wr_raw && wr_data_i[RAW_LOCK_BIT]) lock_q <= 1'b0;
  end
  assign lock_o = lock_q;

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADDR_W'(A_DIV):  rd_data_o[DIV_W-1:0] = sh_div_q;
      ADDR_W'(A_ENA):  rd_data_o[0]         = sh_en_q;
      ADDR_W'(A_SRC):  rd_data_o[SRC_W-1:0] = sh_src_q;
      ADDR_W'(A_CMD):  rd_data_o[CMD_START_BIT] = pend_i;
      ADDR_W'(A_RAW):  rd_data_o[RAW_LOCK_BIT]  = lock_q;
      ADDR_W'(A_STAT): rd_data_o[STAT_BUSY_BIT] = busy_i;
      default:         rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/cck_gen.sv
module cck_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] act_div_i,
  input  logic             act_en_i,
  output logic             div_clk_o,
  output logic             card_clk_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             div_q, byp_q, bypass, tick;

  assign bypass = (act_div_i == '0);
  assign tick   = !bypass && (cnt_q >= act_div_i - DIV_W'(1));

  // a high phase always completes; a new high phase needs enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (bypass) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      div_q <= div_q ? 1'b0 : act_en_i;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  // pass-through gate changes only while the source is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) byp_q <= 1'b0;
    else         byp_q <= bypass & act_en_i;
  end

  assign div_clk_o  = div_q;
  assign card_clk_o = (clk_i & byp_q) | div_q;
endmodule

// File: rtl/card_clk_ctrl.sv
module card_clk_ctrl
  import cck_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned SRC_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              data_busy_i,
  output logic              card_clk_o,
  output logic [SRC_W-1:0]  clk_src_o
);
  logic             cmd_wr, pend, wait_f, apply, err_set, lock, act_en, div_clk;
  logic [DIV_W-1:0] act_div;

  assign cmd_wr = wr_en_i && (wr_addr_i == ADDR_W'(A_CMD));

  cck_upd #(.DATA_W(DATA_W)) u_upd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_wr_i  (cmd_wr),
    .cmd_data_i(wr_data_i),
    .busy_i    (data_busy_i),
    .pend_o    (pend),
    .wait_o    (wait_f),
    .apply_o   (apply),
    .err_set_o (err_set)
  );

  cck_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W), .SRC_W(SRC_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .apply_i   (apply),
    .err_set_i (err_set),
    .pend_i    (pend),
    .busy_i    (data_busy_i),
    .act_div_o (act_div),
    .act_en_o  (act_en),
    .act_src_o (clk_src_o),
    .lock_o    (lock),
    .rd_data_o (rd_data_o)
  );

  cck_gen #(.DIV_W(DIV_W)) u_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_div_i (act_div),
    .act_en_i  (act_en),
    .div_clk_o (div_clk),
    .card_clk_o(card_clk_o)
  );
endmodule

// File: rtl/cck_chk.sv
module cck_chk #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned SRC_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_wr,
  input logic             pend,
  input logic             wait_f,
  input logic             data_busy_i,
  input logic             lock,
  input logic             act_en,
  input logic             div_clk,
  input logic [DIV_W-1:0] act_div,
  input logic [SRC_W-1:0] clk_src_o
);
  AST_UPD_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend && !(wait_f && data_busy_i) |=> !pend); // R3

  AST_UPD_DEFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend && wait_f && data_busy_i |=> pend); // R6

  AST_LOCK_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && pend |=> lock); // R7

  AST_SRC_ON_APPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_src_o != $past(clk_src_o)) |-> $fell(pend)); // R10

  AST_DIV_ON_APPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_div != $past(act_div)) || (act_en != $past(act_en)) |-> $fell(pend)); // R2

  AST_RISE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_clk) |-> $past(act_en)); // R9
endmodule

bind card_clk_ctrl cck_chk #(.DIV_W(DIV_W), .SRC_W(SRC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_wr     (cmd_wr),
  .pend       (pend),
  .wait_f     (wait_f),
  .data_busy_i(data_busy_i),
  .lock       (lock),
  .act_en     (act_en),
  .div_clk    (div_clk),
  .act_div    (act_div),
  .clk_src_o  (clk_src_o)
);

// File: tb/card_clk_ctrl_tb.sv
module card_clk_ctrl_tb;
  localparam logic [2:0] A_DIV = 3'd0, A_ENA = 3'd1, A_SRC = 3'd2,
                         A_CMD = 3'd3, A_RAW = 3'd4, A_STAT = 3'd5;
  localparam logic [31:0] C_START = 32'h8000_0000;
  localparam logic [31:0] C_UPD   = 32'h0020_0000;
  localparam logic [31:0] C_WAIT  = 32'h0000_2000;
  localparam logic [31:0] B_LOCK  = 32'h0000_1000;
  localparam logic [31:0] B_BUSY  = 32'h0000_0200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        busy = 1'b0;
  logic        card_clk;
  logic [1:0]  clk_src;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  card_clk_ctrl u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .data_busy_i(busy),
    .card_clk_o (card_clk),
    .clk_src_o  (clk_src)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic do_update();
    reg_wr(A_CMD, C_START | C_UPD);
    @(negedge clk);
  endtask

  task automatic count_high(input int cycles, output int hi);
    hi = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (card_clk) hi++;
    end
  endtask

  task automatic measure(output int hi, output int lo);
    hi = 0; lo = 0;
    do @(negedge clk); while (card_clk);
    do @(negedge clk); while (!card_clk);
    while (card_clk) begin hi++; @(negedge clk); end
    while (!card_clk) begin lo++; @(negedge clk); end
  endtask

  task automatic set_div(input int d);
    reg_wr(A_ENA, 0);  do_update();
    reg_wr(A_DIV, d);  do_update();
    reg_wr(A_ENA, 1);  do_update();
  endtask

  task automatic t_reset();
    logic [31:0] v; int hi;
    reg_rd(A_CMD, v); chk("R1 pending", v, 0);
    reg_rd(A_RAW, v); chk("R1 raw", v, 0);
    chk("R1 src", 32'(clk_src), 0);
    count_high(20, hi); chk("R1 clock low", hi, 0);
  endtask

  task automatic t_shadow();
    logic [31:0] v; int hi;
    reg_wr(A_DIV, 4); reg_wr(A_ENA, 1); reg_wr(A_SRC, 1);
    count_high(30, hi); chk("R2 clock idle before update", hi, 0);
    chk("R2 src unchanged", 32'(clk_src), 0);
    reg_rd(A_DIV, v); chk("R2 staged div readback", v, 4);
  endtask

  task automatic t_update();
    logic [31:0] v;
    reg_wr(A_CMD, C_START | C_UPD);
    reg_rd(A_CMD, v); chk("R3 start reads 1", v, C_START);
    @(negedge clk);
    reg_rd(A_CMD, v); chk("R3 start self-clears", v, 0);
    chk("R10 src applied", 32'(clk_src), 1);
  endtask

  task automatic t_div();
    int hi, lo;
    measure(hi, lo); chk("R4 div4 high", hi, 4); chk("R4 div4 low", lo, 4);
    set_div(1);
    measure(hi, lo); chk("R4 div1 high", hi, 1); chk("R4 div1 low", lo, 1);
    set_div(255);
    measure(hi, lo); chk("R4 div255 high", hi, 255); chk("R4 div255 low", lo, 255);
  endtask

  task automatic t_runt();
    int hi, more;
    set_div(8);
    reg_wr(A_ENA, 0);
    do @(negedge clk); while (card_clk);
    do @(negedge clk); while (!card_clk);
    reg_wr(A_CMD, C_START | C_UPD);
    hi = 3;
    while (card_clk) begin hi++; @(negedge clk); end
    chk("R9 full high phase on disable", hi - 1, 8);
    count_high(40, more); chk("R9 stays low after disable", more, 0);
  endtask

  task automatic t_bypass();
    int hi_p, lo_n;
    reg_wr(A_DIV, 0); do_update();
    reg_wr(A_ENA, 1); do_update();
    repeat (2) @(negedge clk);
    hi_p = 0; lo_n = 0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1; if (card_clk) hi_p++;
      @(negedge clk); #1; if (card_clk) lo_n++;
    end
    chk("R5 follows source high", hi_p, 6);
    chk("R5 follows source low", lo_n, 0);
    reg_wr(A_ENA, 0); do_update();
    repeat (2) @(negedge clk);
    hi_p = 0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1; if (card_clk) hi_p++;
    end
    chk("R5 gated off", hi_p, 0);
  endtask

  task automatic t_defer();
    logic [31:0] v;
    busy = 1'b1;
    reg_rd(A_STAT, v); chk("R6 busy status", v, B_BUSY);
    reg_wr(A_SRC, 3);
    reg_wr(A_CMD, C_START | C_UPD | C_WAIT);
    repeat (10) @(negedge clk);
    reg_rd(A_CMD, v); chk("R6 held while busy", v, C_START);
    chk("R6 src not applied", 32'(clk_src), 1);
    reg_wr(A_CMD, C_START | C_UPD);
    reg_rd(A_RAW, v); chk("R7 lock flag set", v, B_LOCK);
    reg_rd(A_CMD, v); chk("R7 pending kept", v, C_START);
    busy = 1'b0;
    @(negedge clk);
    reg_rd(A_CMD, v); chk("R6 applied after busy drops", v, 0);
    chk("R6 src applied", 32'(clk_src), 3);
    reg_wr(A_RAW, B_LOCK);
    reg_rd(A_RAW, v); chk("R7 lock flag cleared", v, 0);
  endtask

  task automatic t_nowait();
    busy = 1'b1;
    reg_wr(A_SRC, 2);
    reg_wr(A_CMD, C_START | C_UPD);
    @(negedge clk);
    chk("R6 busy ignored without wait", 32'(clk_src), 2);
    busy = 1'b0;
  endtask

  task automatic t_plain();
    logic [31:0] v;
    reg_wr(A_SRC, 1);
    reg_wr(A_CMD, C_START);
    reg_rd(A_CMD, v); chk("R8 start alone not pending", v, 0);
    reg_wr(A_CMD, C_UPD);
    reg_rd(A_CMD, v); chk("R8 update bit alone not pending", v, 0);
    repeat (4) @(negedge clk);
    chk("R8 src unchanged", 32'(clk_src), 2);
    reg_rd(A_RAW, v); chk("R8 no lock flag", v, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_shadow();
    t_update();
    t_div();
    t_runt();
    t_bypass();
    t_defer();
    t_nowait();
    t_plain();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule